// File: doc/BRIEF.md
# Transmit Descriptor Ring Poller

This block walks a circular list of transmit descriptors kept in a small on-chip word RAM. It streams the bytes of every buffer that the controller owns to a byte-wide MAC-side handshake interface. A scan begins either on a one-cycle demand pulse or when a periodic poll timer expires. The scan continues through consecutive controller-owned descriptors and ends at the first host-owned one. The next scan resumes at that same index.

Each descriptor is four 16-bit words placed at `ring_base + 4*index`:

| Word | Contents |
|------|----------|
| +0 | Byte address of the buffer. |
| +1 | Flag byte in bits 7:0. Bits 15:8 are kept unchanged. |
| +2 | Byte count, stored negated in bits 11:0, with bits 15:12 set to ones. |
| +3 | Completion status, written by the block. |

A frame may span several descriptors. It ends at the descriptor that carries the end-of-packet flag. For each descriptor the block does the following:

- Intermediate descriptors are handed back to the host by clearing their ownership bit.
- On the final descriptor, the status word is written first. The flag byte follows, with ownership cleared, retry flags and the error summary. The `tx_done` pulse comes last.

Host software fills descriptors and buffers through a plain write port, and can read any word back.

Top module: `tx_ring_poller`

## Requirements
- R1: After a synchronous active-low reset, `mac_valid`, `mac_last`, `tx_done` and `busy` are 0 and the ring index is 0.
- R2: A `tx_demand` pulse while idle makes `busy` high on the next cycle. It causes an immediate scan without waiting for the poll timer.
- R3: Without any demand, a scan starts by itself after POLL_PERIOD idle cycles.
- R4: A descriptor sends N bytes, where N is the two's complement of bits 11:0 of word +2. The bytes start at byte address word +0, and byte address a lies in RAM word a/2, in bits 7:0 for even a and bits 15:8 for odd a. `mac_data` holds steady while `mac_ready` is low. `mac_last` marks only the final byte of a descriptor whose flag bit 0 (end of packet) is set.
- R5: At the end of a frame, status word +3 is written, then flag word +1 is written with bit 7 (ownership) cleared and bits 1:0 (start/end of packet) kept. `tx_done` pulses for one cycle, in the cycle after the flag write.
- R6: A descriptor without flag bit 0 continues the frame into the next descriptor. Its own flag byte is written back with only bit 7 cleared.
- R7: The ring holds 2^`ring_log2` descriptors, and the index wraps modulo that size.
- R8: A scan stops at the first descriptor whose flag bit 7 is 0 and leaves that descriptor unchanged. The next scan starts at that index.
- R9: If `mac_ready` stays low for STALL_LIMIT cycles inside a frame, the frame is abandoned. Status bit 14 (underflow) and flag bit 6 (error summary) are set.
- R10: If a frame reaches its starting descriptor again, or reaches a host-owned descriptor, before any end-of-packet flag, the last descriptor visited gets status bit 15 (buffer error) and flag bit 6.
- R11: MAC-side pulses seen while a byte is being sent are recorded as follows:
  - exactly one `mac_retry` pulse sets flag bit 3;
  - two or more `mac_retry` pulses set flag bit 4;
  - `mac_defer` sets flag bit 2;
  - `mac_fail16` sets status bit 10;
  - `mac_nocarrier` sets status bit 11;
  - `mac_latecol` sets status bit 12;
  - any of the three status causes above also sets flag bit 6;
  - status bits 9:0 take the count of bytes already accepted when the first retry arrived.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_demand | input | 1 | One-cycle request for an immediate scan |
| ring_base | input | ADDR_W | Word address of descriptor 0 |
| ring_log2 | input | 3 | Log2 of the number of descriptors |
| hst_we | input | 1 | Host write strobe |
| hst_addr | input | ADDR_W | Host word address |
| hst_wdata | input | 16 | Host write data |
| hst_rdata | output | 16 | RAM word at `hst_addr` |
| mac_valid | output | 1 | Byte on `mac_data` is valid |
| mac_data | output | 8 | Byte to the MAC |
| mac_last | output | 1 | Final byte of the frame |
| mac_ready | input | 1 | MAC accepts the byte this cycle |
| mac_defer | input | 1 | Frame was deferred |
| mac_retry | input | 1 | One collision retry occurred |
| mac_fail16 | input | 1 | Retries exhausted |
| mac_nocarrier | input | 1 | Carrier was lost |
| mac_latecol | input | 1 | Late collision |
| tx_done | output | 1 | One-cycle pulse when a frame has completed |
| busy | output | 1 | A scan is in progress |

## Verification
The assertions assume three things about the environment:

- The host does not rewrite a buffer or descriptor while the block is streaming from it.
- `tx_demand` is a single-cycle pulse.
- MAC status pulses only arrive alongside accepted bytes.

The bench follows these rules by construction:

- It writes the ownership flag word last, after the buffer, count and base, so a periodic poll never sees a half-written descriptor.
- Its MAC model raises the status inputs only in the cycle in which it accepts a chosen byte index.
- It holds `mac_ready` low only in the stall scenario.

// File: rtl/tx_ring_pkg.sv
// Package: shared encodings for the transmit ring poller.
// Flag-byte and status-word bit positions are fixed by the descriptor
// layout that host software relies on.
package tx_ring_pkg;
    localparam int LOG2_W = 3;
    localparam int IDX_W  = (1 << LOG2_W) - 1;

    // flag byte (descriptor word 1, bits 7:0)
    localparam int F_END   = 0;
    localparam int F_START = 1;
    localparam int F_DEFER = 2;
    localparam int F_ONE   = 3;
    localparam int F_MORE  = 4;
    localparam int F_ERR   = 6;
    localparam int F_OWN   = 7;

    // descriptor word offsets
    localparam logic [1:0] W_BASE = 2'd0;
    localparam logic [1:0] W_FLAG = 2'd1;
    localparam logic [1:0] W_LEN  = 2'd2;
    localparam logic [1:0] W_STAT = 2'd3;

    typedef enum logic [2:0] {
        S_IDLE, S_FLAG, S_LEN, S_BASE, S_SEND, S_END, S_STAT, S_CLR
    } eng_state_t;
endpackage

// File: rtl/tx_desc_ram.sv
// Module: word RAM shared by host and engine.
// Assumes: combinational reads on both ports; when both write the same
// word in one cycle the host write lands last.
module tx_desc_ram #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic [ADDR_W-1:0] eng_addr,
    input  logic              eng_we,
    input  logic [15:0]       eng_wdata,
    output logic [15:0]       eng_rdata,
    input  logic [ADDR_W-1:0] hst_addr,
    input  logic              hst_we,
    input  logic [15:0]       hst_wdata,
    output logic [15:0]       hst_rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [15:0] mem [DEPTH];

    // Write both ports; the host write takes effect last.
    always_ff @(posedge clk) begin
        if (eng_we) mem[eng_addr] <= eng_wdata;
        if (hst_we) mem[hst_addr] <= hst_wdata;
    end

    // Asynchronous read ports.
    assign eng_rdata = mem[eng_addr];
    assign hst_rdata = mem[hst_addr];
endmodule

// File: rtl/tx_poll_timer.sv
// Module: decides when a ring scan starts.
// A demand pulse starts at once when idle, or is held pending while a scan
// runs. Otherwise a scan starts after POLL_PERIOD idle cycles.
module tx_poll_timer #(
    parameter int POLL_PERIOD = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic demand,
    input  logic idle,
    output logic start
);
    localparam int CNT_W = $clog2(POLL_PERIOD + 1);

    logic [CNT_W-1:0] cnt;
    logic             pend;

    assign start = idle && (demand || pend || (cnt == CNT_W'(POLL_PERIOD - 1)));

    // Count idle cycles and remember demands that arrive while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            pend <= 1'b0;
        end else if (start) begin
            cnt  <= '0;
            pend <= 1'b0;
        end else begin
            if (idle) cnt <= cnt + 1'b1;
            if (demand && !idle) pend <= 1'b1;
        end
    end
endmodule

// File: rtl/tx_ring_engine.sv
// Module: descriptor walk and byte streaming state machine.
// Assumes a RAM with combinational read: one word is read or written per
// cycle. The ring index is masked by the current ring size on every use.
module tx_ring_engine
    import tx_ring_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int STALL_LIMIT = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [ADDR_W-1:0]    ring_base,
    input  logic [LOG2_W-1:0]    ring_log2,
    output logic [ADDR_W-1:0]    eng_addr,
    output logic                 eng_we,
    output logic [15:0]          eng_wdata,
    input  logic [15:0]          eng_rdata,
    output logic                 mac_valid,
    output logic [7:0]           mac_data,
    output logic                 mac_last,
    input  logic                 mac_ready,
    input  logic                 mac_defer,
    input  logic                 mac_retry,
    input  logic                 mac_fail16,
    input  logic                 mac_nocarrier,
    input  logic                 mac_latecol,
    output logic                 tx_done,
    output logic                 busy,
    output logic                 idle
);
    localparam int STALL_W = $clog2(STALL_LIMIT + 1);

    eng_state_t          state;
    logic [IDX_W-1:0]    cur_idx, start_idx, idx_mask, cur_m, nxt_idx;
    logic [IDX_W:0]      size_oh;
    logic [15:0]         flags_q;
    logic [11:0]         cnt, sent;
    logic [ADDR_W:0]     ptr;
    logic [STALL_W-1:0]  stall;
    logic                cont, final_q;
    logic                defer_q, fail_q, lcar_q, lcol_q, uflo_q, buff_q, tdr_seen;
    logic [1:0]          retry_n;
    logic [9:0]          tdr_q;
    logic                any_err;
    logic [7:0]          fin_flags;
    logic [15:0]         status_w;
    logic                unused_rd;

    assign size_oh  = (IDX_W + 1)'(1) << ring_log2;
    assign idx_mask = size_oh[IDX_W-1:0] - 1'b1;
    assign cur_m    = cur_idx & idx_mask;
    assign nxt_idx  = (cur_m + 1'b1) & idx_mask;
    assign unused_rd = ^eng_rdata[15:ADDR_W+1];

    function automatic logic [ADDR_W-1:0] daddr(input logic [ADDR_W-1:0] b,
                                                input logic [IDX_W-1:0] i,
                                                input logic [1:0] w);
        return b + ADDR_W'({i, w});
    endfunction

    assign any_err   = fail_q | lcar_q | lcol_q | uflo_q | buff_q;
    assign fin_flags = {1'b0, any_err, 1'b0, retry_n[1], (retry_n == 2'd1),
                        defer_q, flags_q[F_START], flags_q[F_END]};
    assign status_w  = {buff_q, uflo_q, 1'b0, lcol_q, lcar_q, fail_q, tdr_q};

    // Select the RAM word touched in each state.
    always_comb begin
        unique case (state)
            S_FLAG:  eng_addr = daddr(ring_base, cur_m, W_FLAG);
            S_LEN:   eng_addr = daddr(ring_base, cur_m, W_LEN);
            S_BASE:  eng_addr = daddr(ring_base, cur_m, W_BASE);
            S_SEND:  eng_addr = ptr[ADDR_W:1];
            S_END:   eng_addr = daddr(ring_base, nxt_idx, W_FLAG);
            S_STAT:  eng_addr = daddr(ring_base, cur_m, W_STAT);
            S_CLR:   eng_addr = daddr(ring_base, cur_m, W_FLAG);
            default: eng_addr = '0;
        endcase
    end

    assign eng_we    = (state == S_STAT) || (state == S_CLR);
    assign eng_wdata = (state == S_STAT) ? status_w :
                       {flags_q[15:8], final_q ? fin_flags : (flags_q[7:0] & 8'h7F)};

    assign mac_valid = (state == S_SEND);
    assign mac_data  = ptr[0] ? eng_rdata[15:8] : eng_rdata[7:0];
    assign mac_last  = mac_valid && (cnt == 12'd1) && flags_q[F_END];
    assign busy      = (state != S_IDLE);
    assign idle      = (state == S_IDLE);

    // Descriptor walk, byte streaming and completion bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;   cur_idx <= '0; start_idx <= '0; flags_q <= '0;
            cnt <= '0;         sent <= '0;    ptr <= '0;       stall <= '0;
            cont <= 1'b0;      final_q <= 1'b0; tx_done <= 1'b0;
            defer_q <= 1'b0;   fail_q <= 1'b0; lcar_q <= 1'b0; lcol_q <= 1'b0;
            uflo_q <= 1'b0;    buff_q <= 1'b0; tdr_seen <= 1'b0;
            retry_n <= '0;     tdr_q <= '0;
        end else begin
            tx_done <= 1'b0;
            unique case (state)
                S_IDLE: if (start) state <= S_FLAG;
                S_FLAG: begin
                    if (!eng_rdata[F_OWN]) begin
                        state <= S_IDLE;
                        cont  <= 1'b0;
                    end else begin
                        flags_q <= eng_rdata;
                        state   <= S_LEN;
                        if (!cont) begin
                            start_idx <= cur_m;  sent <= '0;
                            defer_q <= 1'b0; fail_q <= 1'b0; lcar_q <= 1'b0;
                            lcol_q <= 1'b0;  uflo_q <= 1'b0; buff_q <= 1'b0;
                            tdr_seen <= 1'b0; retry_n <= '0; tdr_q <= '0;
                        end
                    end
                end
                S_LEN: begin
                    cnt   <= 12'd0 - eng_rdata[11:0];
                    state <= S_BASE;
                end
                S_BASE: begin
                    ptr   <= eng_rdata[ADDR_W:0];
                    stall <= '0;
                    state <= (cnt == 12'd0) ? S_END : S_SEND;
                end
                S_SEND: begin
                    if (mac_retry) begin
                        if (retry_n != 2'd2) retry_n <= retry_n + 1'b1;
                        if (!tdr_seen) tdr_q <= (sent > 12'd1023) ? 10'd1023 : sent[9:0];
                        tdr_seen <= 1'b1;
                    end
                    if (mac_defer)     defer_q <= 1'b1;
                    if (mac_fail16)    fail_q  <= 1'b1;
                    if (mac_nocarrier) lcar_q  <= 1'b1;
                    if (mac_latecol)   lcol_q  <= 1'b1;
                    if (mac_ready) begin
                        ptr   <= ptr + 1'b1;
                        cnt   <= cnt - 1'b1;
                        sent  <= sent + 1'b1;
                        stall <= '0;
                        if (cnt == 12'd1) state <= S_END;
                    end else if (stall == STALL_W'(STALL_LIMIT - 1)) begin
                        uflo_q  <= 1'b1;
                        final_q <= 1'b1;
                        state   <= S_STAT;
                    end else begin
                        stall <= stall + 1'b1;
                    end
                end
                S_END: begin
                    if (flags_q[F_END]) begin
                        final_q <= 1'b1;
                        state   <= S_STAT;
                    end else if (nxt_idx == start_idx || !eng_rdata[F_OWN]) begin
                        buff_q  <= 1'b1;
                        final_q <= 1'b1;
                        state   <= S_STAT;
                    end else begin
                        final_q <= 1'b0;
                        state   <= S_CLR;
                    end
                end
                S_STAT: state <= S_CLR;
                S_CLR: begin
                    cur_idx <= nxt_idx;
                    cont    <= !final_q;
                    tx_done <= final_q;
                    state   <= S_FLAG;
                end
                default: state <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/tx_ring_poller.sv
// Module: top of the transmit ring poller.
// Connects the scan timer, the descriptor engine and the shared word RAM.
// Assumes the host keeps its hands off descriptors it has handed over.
module tx_ring_poller
    import tx_ring_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int POLL_PERIOD = 64,
    parameter int STALL_LIMIT = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_demand,
    input  logic [ADDR_W-1:0] ring_base,
    input  logic [2:0]        ring_log2,
    input  logic              hst_we,
    input  logic [ADDR_W-1:0] hst_addr,
    input  logic [15:0]       hst_wdata,
    output logic [15:0]       hst_rdata,
    output logic              mac_valid,
    output logic [7:0]        mac_data,
    output logic              mac_last,
    input  logic              mac_ready,
    input  logic              mac_defer,
    input  logic              mac_retry,
    input  logic              mac_fail16,
    input  logic              mac_nocarrier,
    input  logic              mac_latecol,
    output logic              tx_done,
    output logic              busy
);
    logic              start, idle, eng_we;
    logic [ADDR_W-1:0] eng_addr;
    logic [15:0]       eng_wdata, eng_rdata;

    tx_poll_timer #(.POLL_PERIOD(POLL_PERIOD)) u_timer (
        .clk(clk), .rst_n(rst_n), .demand(tx_demand), .idle(idle), .start(start)
    );

    tx_ring_engine #(.ADDR_W(ADDR_W), .STALL_LIMIT(STALL_LIMIT)) u_engine (
        .clk(clk), .rst_n(rst_n), .start(start),
        .ring_base(ring_base), .ring_log2(ring_log2),
        .eng_addr(eng_addr), .eng_we(eng_we), .eng_wdata(eng_wdata),
        .eng_rdata(eng_rdata),
        .mac_valid(mac_valid), .mac_data(mac_data), .mac_last(mac_last),
        .mac_ready(mac_ready), .mac_defer(mac_defer), .mac_retry(mac_retry),
        .mac_fail16(mac_fail16), .mac_nocarrier(mac_nocarrier),
        .mac_latecol(mac_latecol),
        .tx_done(tx_done), .busy(busy), .idle(idle)
    );

    tx_desc_ram #(.ADDR_W(ADDR_W)) u_ram (
        .clk(clk), .eng_addr(eng_addr), .eng_we(eng_we), .eng_wdata(eng_wdata),
        .eng_rdata(eng_rdata), .hst_addr(hst_addr), .hst_we(hst_we),
        .hst_wdata(hst_wdata), .hst_rdata(hst_rdata)
    );
endmodule

// File: rtl/tx_ring_poller_chk.sv
// Module: protocol checker bound to the poller top.
// Assumes: single-cycle demand pulses; buffers untouched while in flight.
module tx_ring_poller_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tx_demand,
    input logic       mac_valid,
    input logic [7:0] mac_data,
    input logic       mac_last,
    input logic       mac_ready,
    input logic       tx_done,
    input logic       busy,
    input logic       eng_we
);
    // R1: reset clears the outputs
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!mac_valid && !tx_done && !busy));

    // R2: demand while idle begins a scan on the next cycle
    a_r2_demand_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_demand && !busy) |=> busy);

    // R4: the last marker only accompanies a valid byte
    a_r4_last_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        mac_last |-> mac_valid);

    // R4: a held byte does not change until it is taken or abandoned
    a_r4_data_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mac_valid && !mac_ready) |=> (!mac_valid || $stable(mac_data)));

    // R5: completion follows a RAM write-back
    a_r5_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> $past(eng_we));

    // R5: completion is a single-cycle pulse
    a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |=> !tx_done);
endmodule

bind tx_ring_poller tx_ring_poller_chk u_chk (
    .clk(clk), .rst_n(rst_n), .tx_demand(tx_demand), .mac_valid(mac_valid),
    .mac_data(mac_data), .mac_last(mac_last), .mac_ready(mac_ready),
    .tx_done(tx_done), .busy(busy), .eng_we(eng_we)
);

// File: tb/tx_ring_poller_bench.sv
// Scoreboard bench: tasks queue expected bytes; a MAC model pops and compares.
module tx_ring_poller_bench;
    localparam int ADDR_W = 8;
    localparam int POLL   = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_demand = 1'b0;
    logic [ADDR_W-1:0] ring_base = '0;
    logic [2:0] ring_log2 = 3'd2;
    logic hst_we = 1'b0;
    logic [ADDR_W-1:0] hst_addr = '0;
    logic [15:0] hst_wdata = '0;
    logic [15:0] hst_rdata;
    logic mac_valid, mac_last, tx_done, busy;
    logic [7:0] mac_data;
    logic mac_ready = 1'b0, mac_defer = 1'b0, mac_retry = 1'b0;
    logic mac_fail16 = 1'b0, mac_nocarrier = 1'b0, mac_latecol = 1'b0;

    int tests = 0, fails = 0, done_cnt = 0, frame_bytes = 0;
    bit stall_en = 1'b0;
    int retry_a = -1, retry_b = -1, defer_at = -1, lcol_at = -1, lcar_at = -1, fail_at = -1;
    logic [8:0] exp_q[$];

    always #5 clk = ~clk;

    tx_ring_poller #(.ADDR_W(ADDR_W), .POLL_PERIOD(POLL), .STALL_LIMIT(8)) u_tx_ring_poller (
        .clk(clk), .rst_n(rst_n), .tx_demand(tx_demand), .ring_base(ring_base),
        .ring_log2(ring_log2), .hst_we(hst_we), .hst_addr(hst_addr),
        .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .mac_valid(mac_valid),
        .mac_data(mac_data), .mac_last(mac_last), .mac_ready(mac_ready),
        .mac_defer(mac_defer), .mac_retry(mac_retry), .mac_fail16(mac_fail16),
        .mac_nocarrier(mac_nocarrier), .mac_latecol(mac_latecol),
        .tx_done(tx_done), .busy(busy)
    );

    function automatic logic [7:0] pat(input int a);
        return 8'(a) ^ 8'h5A;
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // MAC model and scoreboard monitor: decides readiness, pops expected bytes.
    always @(negedge clk) begin
        logic rdy;
        logic [8:0] e;
        rdy = rst_n && !(stall_en && frame_bytes >= 2);
        mac_ready = rdy;
        mac_retry = 1'b0; mac_defer = 1'b0; mac_latecol = 1'b0;
        mac_nocarrier = 1'b0; mac_fail16 = 1'b0;
        if (mac_valid && rdy) begin
            mac_retry     = (frame_bytes == retry_a) || (frame_bytes == retry_b);
            mac_defer     = (frame_bytes == defer_at);
            mac_latecol   = (frame_bytes == lcol_at);
            mac_nocarrier = (frame_bytes == lcar_at);
            mac_fail16    = (frame_bytes == fail_at);
            if (exp_q.size() == 0) begin
                chk("R4 unexpected byte", {7'd0, mac_last, mac_data}, 16'h0);
            end else begin
                e = exp_q.pop_front();
                chk("R4 byte/last", {7'd0, mac_last, mac_data}, {7'd0, e});
            end
            frame_bytes++;
        end
        if (tx_done) begin
            done_cnt++;
            frame_bytes = 0;
        end
    end

    task automatic wr(input int a, input logic [15:0] d);
        @(negedge clk);
        hst_we = 1'b1; hst_addr = ADDR_W'(a); hst_wdata = d;
        @(negedge clk);
        hst_we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [15:0] d);
        @(negedge clk);
        hst_addr = ADDR_W'(a);
        #1 d = hst_rdata;
    endtask

    // Write base, count, status, then the flag word last.
    task automatic set_desc(input int i, input int base, input int n, input logic [7:0] fl);
        wr(4*i + 0, 16'(base));
        wr(4*i + 2, 16'hF000 | (16'(-n) & 16'h0FFF));
        wr(4*i + 3, 16'h0000);
        wr(4*i + 1, {8'h00, fl});
    endtask

    task automatic expect_bytes(input int base, input int n, input bit last_end);
        for (int k = 0; k < n; k++)
            exp_q.push_back({(last_end && k == n - 1), pat(base + k)});
    endtask

    task automatic wait_done(input int target);
        int t;
        t = 0;
        while (done_cnt < target && t < 2000) begin
            @(negedge clk);
            t++;
        end
        chk("R5 completion seen", 16'(done_cnt >= target), 16'h1);
    endtask

    task automatic pulse_demand();
        @(negedge clk);
        tx_demand = 1'b1;
        @(negedge clk);
        tx_demand = 1'b0;
    endtask

    task automatic chk_word(input string req, input int a, input logic [15:0] exp);
        logic [15:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    initial begin
        int base_done, t;
        repeat (3) @(negedge clk);
        chk("R1 reset outputs", {12'd0, mac_valid, mac_last, tx_done, busy}, 16'h0);
        rst_n = 1'b1;
        for (int w = 0; w < 16; w++) wr(w, 16'h0000);
        for (int w = 64; w < 256; w++) wr(w, {pat(2*w + 1), pat(2*w)});

        // R2 / R8: demand with every descriptor host-owned
        @(negedge clk);
        tx_demand = 1'b1;
        @(negedge clk);
        tx_demand = 1'b0;
        chk("R2 busy after demand", 16'(busy), 16'h1);
        repeat (4) @(negedge clk);
        chk("R8 scan stops at host-owned", 16'(busy), 16'h0);
        chk_word("R8 host-owned descriptor untouched", 1, 16'h0000);

        // R4 / R5: single descriptor frame
        base_done = done_cnt;
        expect_bytes(128, 5, 1);
        set_desc(0, 128, 5, 8'h83);
        pulse_demand();
        wait_done(base_done + 1);
        chk("R4 all bytes taken", 16'(exp_q.size()), 16'h0);
        chk_word("R5 clean status", 3, 16'h0000);
        chk_word("R5 ownership cleared", 1, 16'h0003);

        // R6: frame spread over descriptors 1 and 2
        base_done = done_cnt;
        expect_bytes(161, 3, 0);
        expect_bytes(201, 2, 1);
        set_desc(2, 201, 2, 8'h81);
        set_desc(1, 161, 3, 8'h82);
        pulse_demand();
        wait_done(base_done + 1);
        repeat (4) @(negedge clk);
        chk("R6 one completion per frame", 16'(done_cnt - base_done), 16'h1);
        chk_word("R6 middle descriptor released", 5, 16'h0002);
        chk_word("R6 final descriptor", 9, 16'h0001);

        // R7 / R8: resume at descriptor 3, then wrap to 0
        base_done = done_cnt;
        expect_bytes(180, 2, 1);
        expect_bytes(141, 1, 1);
        set_desc(0, 141, 1, 8'h83);
        set_desc(3, 180, 2, 8'h83);
        pulse_demand();
        wait_done(base_done + 2);
        chk("R7 R8 order kept", 16'(exp_q.size()), 16'h0);
        chk_word("R7 wrapped descriptor done", 1, 16'h0003);

        // R3: periodic poll without demand
        base_done = done_cnt;
        expect_bytes(150, 4, 1);
        set_desc(1, 150, 4, 8'h83);
        t = 0;
        while (done_cnt == base_done && t < 400) begin
            @(negedge clk);
            t++;
        end
        chk("R3 poll within period", 16'(t <= POLL + 30), 16'h1);

        // R9: MAC stalls after two bytes
        base_done = done_cnt;
        stall_en = 1'b1;
        expect_bytes(210, 2, 0);
        set_desc(2, 210, 4, 8'h83);
        pulse_demand();
        wait_done(base_done + 1);
        stall_en = 1'b0;
        chk_word("R9 underflow status", 11, 16'h4000);
        chk_word("R9 error summary", 9, 16'h0043);

        // R10: chain 3,0,1,2 with no end flag
        base_done = done_cnt;
        expect_bytes(133, 1, 0);
        expect_bytes(130, 1, 0);
        expect_bytes(131, 1, 0);
        expect_bytes(132, 1, 0);
        set_desc(0, 130, 1, 8'h80);
        set_desc(1, 131, 1, 8'h80);
        set_desc(2, 132, 1, 8'h80);
        set_desc(3, 133, 1, 8'h82);
        pulse_demand();
        wait_done(base_done + 1);
        chk_word("R10 buffer error status", 11, 16'h8000);
        chk_word("R10 error flag", 9, 16'h0040);
        chk_word("R10 chained descriptor released", 1, 16'h0000);

        // R11: two retries (first at byte 2), defer, late collision
        base_done = done_cnt;
        retry_a = 2; retry_b = 4; defer_at = 1; lcol_at = 3;
        expect_bytes(220, 6, 1);
        set_desc(3, 220, 6, 8'h83);
        pulse_demand();
        wait_done(base_done + 1);
        chk_word("R11 late collision and distance", 15, 16'h1002);
        chk_word("R11 more retries, deferred, error", 13, 16'h0057);

        // R11: one retry at byte 0, carrier loss, retries exhausted
        base_done = done_cnt;
        retry_a = 0; retry_b = -1; defer_at = -1; lcol_at = -1; lcar_at = 1; fail_at = 5;
        expect_bytes(230, 6, 1);
        set_desc(0, 230, 6, 8'h83);
        pulse_demand();
        wait_done(base_done + 1);
        retry_a = -1; lcar_at = -1; fail_at = -1;
        chk_word("R11 exhausted and no carrier", 3, 16'h0C00);
        chk_word("R11 one retry flag", 1, 16'h004B);
        chk("R4 queue drained", 16'(exp_q.size()), 16'h0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(200000 * 10);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule